// File: doc/BRIEF.md
# Pipelined Binary-Tree Pattern Counter

This block tallies how often each pattern in a fixed set shows up in a stream of incoming words. The set is held as a binary search tree. Each tree level sits in its own pipeline stage and has its own node and count storage. Level 0 has one node, and every deeper level has twice as many nodes as the one above it. A word enters at the root and descends one level per clock. At each level it steers left when it is smaller than the node and right when it is larger. When it equals a node, that node's counter is bumped, and the word carries a "found" mark down the rest of the pipe. A word that leaves the deepest level unmatched adds one to a miss counter. Because every level works on a different word, a new word can be accepted on every clock.

Nodes are addressed in heap order. Address `a` (from 1 to 2^DEPTH-1) lies on level floor(log2 a), and its children are `2a` and `2a+1`. Software fills the tree through the load port while the block is idle. Results come back one node at a time over a read port that returns the stored pattern and its count.

A small controller sets `busy`. It has three states:
- **IDLE**: the pipe is empty and loads are accepted.
- **FLOW**: a word was taken on the last edge.
- **DRAIN**: input has stopped and words are still in flight.

Its transitions are:
- IDLE→FLOW when `in_valid` is sampled high.
- FLOW→FLOW while `in_valid` stays high.
- FLOW→DRAIN when `in_valid` drops.
- DRAIN→FLOW when input resumes.
- DRAIN→IDLE once no stage and no pending count write is occupied.

Top module: `pattern_tree_counter`

## Requirements
- R1: After synchronous active-high `rst`, `miss_count` is 0, `busy` is 0, `rd_valid` is 0, and every node reads back pattern 0 with count 0.
- R2: A write with `load_en` high to heap address `a` (1..2^DEPTH-1) sets that node's pattern and clears its count. A read with `rd_en` high returns `rd_valid`=1 with that node's pattern and count on the next edge. A read of address 0 gives `rd_valid`=0.
- R3: A word starts at address 1. If it is less than the node at `a` it moves to `2a`; if greater, to `2a+1`. If equal, the count at `a` goes up by exactly one and no deeper node is counted for that word.
- R4: One word is accepted on every clock with `in_valid` high. Identical words on consecutive clocks that match the same node each add one to its count.
- R5: A word that matches no node on its path through all DEPTH levels increments `miss_count` by one. `miss_count` never rises by more than one per clock.
- R6: A load presented while `busy` is high, or while `in_valid` is high, is ignored. The node's pattern and count are left unchanged.
- R7: `busy` is high on the clock after `in_valid` is sampled high. After the last accepted word, `busy` stays high for DEPTH+2 clocks in all, and every count and the miss total are final by the time it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming word present this cycle |
| in_pattern | input | PAT_W | Incoming word |
| load_en | input | 1 | Write a node (taken only when idle) |
| load_addr | input | DEPTH | Heap address of node to write |
| load_pattern | input | PAT_W | Pattern stored in that node |
| rd_en | input | 1 | Read request |
| rd_addr | input | DEPTH | Heap address to read |
| rd_valid | output | 1 | Read result present |
| rd_pattern | output | PAT_W | Stored pattern of the node read |
| rd_count | output | CNT_W | Match count of the node read |
| miss_count | output | CNT_W | Words that matched no node |
| busy | output | 1 | Words in flight; loads refused |

## Verification
Suppose a level steers the wrong way or its compare is wrong. The word then lands on a different node or falls out as a miss, so the read-back of every node and the miss total after the drain disagree with a software walk of the same tree. A lost forwarding path between back-to-back hits shows up as a count one short on a node that received a burst of identical words. The error becomes visible at the first read after `busy` falls, DEPTH+2 clocks after the last word. A controller stuck in the wrong state shows up at once, as a wrong `busy` length or as a load taken or refused at the wrong time.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLOW  = 2'd1,
        ST_DRAIN = 2'd2
    } flow_state_e;

    // position of the highest set bit (0 when the value is 0)
    function automatic int msb_index(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/ptc_level.sv
module ptc_level #(
    parameter int PAT_W = 8,
    parameter int CNT_W = 16,
    parameter int LVL   = 0,
    parameter int IW    = 1
) (
    input  logic             clk,
    input  logic             rst,
    // word arriving at this level
    input  logic             s_valid,
    input  logic             s_hit,
    input  logic [PAT_W-1:0] s_pat,
    input  logic [IW-1:0]    s_idx,
    // word leaving toward the next level
    output logic             n_valid,
    output logic             n_hit,
    output logic [PAT_W-1:0] n_pat,
    output logic [LVL:0]     n_idx,
    output logic             pend,
    // node load
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [PAT_W-1:0] wr_pat,
    // node read-out
    input  logic [IW-1:0]    rd_idx,
    output logic [PAT_W-1:0] rd_pat,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int NODES = 1 << LVL;
    localparam int NIW   = LVL + 1;

    logic [PAT_W-1:0] node_mem [NODES];
    logic [CNT_W-1:0] cnt_mem  [NODES];

    logic             upd_v;
    logic [IW-1:0]    upd_idx;
    logic [CNT_W-1:0] upd_val;

    logic [PAT_W-1:0] node_now;
    logic             is_eq;
    logic             go_right;
    logic             fresh_hit;
    logic [CNT_W-1:0] cur_cnt;

    always_comb begin
        node_now  = node_mem[s_idx];
        is_eq     = (s_pat == node_now);
        go_right  = (s_pat > node_now);
        fresh_hit = s_valid && !s_hit && is_eq;
        // forward a write still in flight to the same node
        if (upd_v && (upd_idx == s_idx)) cur_cnt = upd_val;
        else                             cur_cnt = cnt_mem[s_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_valid <= 1'b0;
            n_hit   <= 1'b0;
            n_pat   <= '0;
            n_idx   <= '0;
            upd_v   <= 1'b0;
            upd_idx <= '0;
            upd_val <= '0;
            for (int i = 0; i < NODES; i++) begin
                node_mem[i] <= '0;
                cnt_mem[i]  <= '0;
            end
        end else begin
            n_valid <= s_valid;
            n_hit   <= s_hit || fresh_hit;
            n_pat   <= s_pat;
            n_idx   <= NIW'({s_idx, go_right});
            upd_v   <= fresh_hit;
            upd_idx <= s_idx;
            upd_val <= cur_cnt + 1'b1;
            if (upd_v) cnt_mem[upd_idx] <= upd_val;
            if (wr_en) begin
                node_mem[wr_idx] <= wr_pat;
                cnt_mem[wr_idx]  <= '0;
            end
        end
    end

    assign pend   = upd_v;
    assign rd_pat = node_mem[rd_idx];
    assign rd_cnt = cnt_mem[rd_idx];

endmodule

// File: rtl/ptc_flow_ctrl.sv
module ptc_flow_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic pipe_occ,
    output logic busy,
    output logic load_ok
);
    import ptc_pkg::*;

    flow_state_e state_q;
    flow_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_FLOW;
            ST_FLOW:  if (!in_valid) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (in_valid)      state_d = ST_FLOW;
                else if (!pipe_occ) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_ok = !in_valid;
            end
            ST_FLOW, ST_DRAIN: begin
                busy    = 1'b1;
                load_ok = 1'b0;
            end
            default: begin
                busy    = 1'b1;
                load_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pattern_tree_counter.sv
module pattern_tree_counter #(
    parameter int DEPTH = 4,
    parameter int PAT_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PAT_W-1:0] in_pattern,
    input  logic             load_en,
    input  logic [DEPTH-1:0] load_addr,
    input  logic [PAT_W-1:0] load_pattern,
    input  logic             rd_en,
    input  logic [DEPTH-1:0] rd_addr,
    output logic             rd_valid,
    output logic [PAT_W-1:0] rd_pattern,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] miss_count,
    output logic             busy
);
    import ptc_pkg::*;

    localparam int LVW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW    = (DEPTH > 1) ? DEPTH - 1 : 1;
    localparam int OCC_W = 2 * DEPTH + 1;

    // pipeline links between levels
    logic [DEPTH:0]   lv_valid;
    logic [DEPTH:0]   lv_hit;
    logic [PAT_W-1:0] lv_pat [DEPTH];
    logic [LW-1:0]    lv_idx [DEPTH];
    logic [DEPTH-1:0] lv_pend;
    logic [OCC_W-1:0] stage_occ;

    logic [PAT_W-1:0] exit_pat_unused;
    logic [DEPTH-1:0] exit_idx_unused;

    // input capture stage
    logic             cap_valid;
    logic [PAT_W-1:0] cap_pat;

    logic             load_ok;
    logic             load_go;
    logic [LVW-1:0]   ld_lvl;
    logic [LVW-1:0]   rd_lvl;
    logic [LW-1:0]    ld_local;
    logic [LW-1:0]    rd_local;
    logic             rd_ok;

    logic [PAT_W-1:0] lvl_rd_pat [DEPTH];
    logic [CNT_W-1:0] lvl_rd_cnt [DEPTH];
    logic [CNT_W-1:0] miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_pat   <= '0;
        end else begin
            cap_valid <= in_valid;
            cap_pat   <= in_pattern;
        end
    end

    assign lv_valid[0] = cap_valid;
    assign lv_hit[0]   = 1'b0;
    assign lv_pat[0]   = cap_pat;
    assign lv_idx[0]   = '0;

    // heap address -> level and offset inside the level
    always_comb begin
        int lvl_a;
        int lvl_b;
        lvl_a    = msb_index(32'(load_addr));
        lvl_b    = msb_index(32'(rd_addr));
        ld_lvl   = LVW'(lvl_a);
        rd_lvl   = LVW'(lvl_b);
        ld_local = LW'(load_addr ^ (DEPTH'(1) << lvl_a));
        rd_local = LW'(rd_addr ^ (DEPTH'(1) << lvl_b));
    end

    assign load_go = load_ok && load_en && (load_addr != '0);
    assign rd_ok   = rd_en && (rd_addr != '0);

    for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
        localparam int IW = (k == 0) ? 1 : k;
        logic [k:0]       nxt_idx;
        logic             nxt_valid;
        logic             nxt_hit;
        logic [PAT_W-1:0] nxt_pat;

        ptc_level #(
            .PAT_W (PAT_W),
            .CNT_W (CNT_W),
            .LVL   (k),
            .IW    (IW)
        ) u_level (
            .clk     (clk),
            .rst     (rst),
            .s_valid (lv_valid[k]),
            .s_hit   (lv_hit[k]),
            .s_pat   (lv_pat[k]),
            .s_idx   (lv_idx[k][IW-1:0]),
            .n_valid (nxt_valid),
            .n_hit   (nxt_hit),
            .n_pat   (nxt_pat),
            .n_idx   (nxt_idx),
            .pend    (lv_pend[k]),
            .wr_en   (load_go && (ld_lvl == LVW'(k))),
            .wr_idx  (IW'(ld_local)),
            .wr_pat  (load_pattern),
            .rd_idx  (IW'(rd_local)),
            .rd_pat  (lvl_rd_pat[k]),
            .rd_cnt  (lvl_rd_cnt[k])
        );

        assign lv_valid[k+1] = nxt_valid;
        assign lv_hit[k+1]   = nxt_hit;

        if (k < DEPTH - 1) begin : g_link
            assign lv_pat[k+1] = nxt_pat;
            assign lv_idx[k+1] = LW'(nxt_idx);
        end else begin : g_exit
            assign exit_pat_unused = nxt_pat;
            assign exit_idx_unused = DEPTH'(nxt_idx);
        end
    end

    assign stage_occ = {lv_pend, lv_valid};

    ptc_flow_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .pipe_occ (|stage_occ),
        .busy     (busy),
        .load_ok  (load_ok)
    );

    // words falling out of the deepest level without a match
    always_ff @(posedge clk) begin
        if (rst) miss_q <= '0;
        else if (lv_valid[DEPTH] && !lv_hit[DEPTH]) miss_q <= miss_q + 1'b1;
    end
    assign miss_count = miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_pattern <= '0;
            rd_count   <= '0;
        end else begin
            rd_valid <= rd_ok;
            if (rd_ok) begin
                rd_pattern <= lvl_rd_pat[rd_lvl];
                rd_count   <= lvl_rd_cnt[rd_lvl];
            end else begin
                rd_pattern <= '0;
                rd_count   <= '0;
            end
        end
    end

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               busy,
    input logic               rd_en,
    input logic [DEPTH-1:0]   rd_addr,
    input logic               rd_valid,
    input logic [CNT_W-1:0]   miss_count,
    input logic [2*DEPTH:0]   stage_occ
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (miss_count == '0 && !busy && !rd_valid));

    assert_read_answers_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr != '0) |=> rd_valid);

    assert_read_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || rd_addr == '0) |=> !rd_valid);

    assert_miss_step_R5: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

    assert_miss_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> $past(busy));

    assert_busy_follows_input_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> busy);

    assert_idle_means_empty_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stage_occ == '0));

endmodule

bind pattern_tree_counter ptc_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_ptc_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .busy       (busy),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .miss_count (miss_count),
    .stage_occ  (stage_occ)
);

// File: tb/pattern_tree_counter_test.sv
`timescale 1ns/1ps
module pattern_tree_counter_test;
    localparam int N  = 4;
    localparam int PW = 8;
    localparam int CW = 16;
    localparam int NN = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [PW-1:0] in_pattern;
    logic          load_en;
    logic [N-1:0]  load_addr;
    logic [PW-1:0] load_pattern;
    logic          rd_en;
    logic [N-1:0]  rd_addr;
    logic          rd_valid;
    logic [PW-1:0] rd_pattern;
    logic [CW-1:0] rd_count;
    logic [CW-1:0] miss_count;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    int m_node [1:NN];
    int m_cnt  [1:NN];
    int m_miss = 0;

    always #5 clk = ~clk;

    pattern_tree_counter #(.DEPTH(N), .PAT_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pattern(in_pattern),
        .load_en(load_en), .load_addr(load_addr), .load_pattern(load_pattern),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_pattern(rd_pattern), .rd_count(rd_count),
        .miss_count(miss_count), .busy(busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // software walk of the tree (R3, R5)
    function automatic void model_apply(input int p);
        int a;
        a = 1;
        for (int l = 0; l < N; l++) begin
            if (p == m_node[a]) begin
                m_cnt[a]++;
                return;
            end
            a = 2 * a + ((p > m_node[a]) ? 1 : 0);
        end
        m_miss++;
    endfunction

    task automatic drive(input logic v, input int p);
        @(negedge clk);
        in_valid   = v;
        in_pattern = PW'(p);
        if (v) model_apply(p);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (!busy) break;
        end
    endtask

    task automatic do_load(input int a, input int p);
        @(negedge clk);
        load_en = 1'b1; load_addr = N'(a); load_pattern = PW'(p);
        @(negedge clk);
        load_en = 1'b0;
        m_node[a] = p;
        m_cnt[a]  = 0;
    endtask

    task automatic read_node(input int a, output int v, output int p, output int c);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = N'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_valid); p = int'(rd_pattern); c = int'(rd_count);
    endtask

    task automatic verify_all(input string tag);
        int v, p, c;
        for (int a = 1; a <= NN; a++) begin
            read_node(a, v, p, c);
            check("R2", {tag, " read valid"}, v, 1);
            check("R2", {tag, " node pattern"}, p, m_node[a]);
            check("R3", {tag, " node count"}, c, m_cnt[a]);
        end
        check("R5", {tag, " miss total"}, int'(miss_count), m_miss);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v, p, c, b, sel;
        void'($urandom(32'd7193));
        rst = 1'b1; in_valid = 1'b0; in_pattern = '0; load_en = 1'b0;
        load_addr = '0; load_pattern = '0; rd_en = 1'b0; rd_addr = '0;
        for (int a = 1; a <= NN; a++) begin m_node[a] = 0; m_cnt[a] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "miss after reset", int'(miss_count), 0);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "rd_valid after reset", int'(rd_valid), 0);
        read_node(9, v, p, c);
        check("R1", "node 9 pattern", p, 0);
        check("R1", "node 9 count", c, 0);

        // balanced search tree: level L offset j holds (2j+1)*(256>>(L+1))
        for (int a = 1; a <= NN; a++) begin
            int l, j;
            l = $clog2(a + 1) - 1;
            j = a - (1 << l);
            do_load(a, (2 * j + 1) * (256 >> (l + 1)));
        end
        verify_all("tree load");
        read_node(0, v, p, c);
        check("R2", "address 0 rd_valid", v, 0);

        // directed descent
        drive(1, 128); drive(1, 16); drive(1, 240); drive(1, 5);
        drive(1, 96);  drive(1, 200); drive(0, 0);  drive(1, 255);
        wait_idle();
        check("R3", "root hit count", m_cnt[1], 1);
        verify_all("directed");

        // back-to-back identical words on one node
        for (int i = 0; i < 5; i++) drive(1, 16);
        for (int i = 0; i < 3; i++) drive(1, 128);
        drive(1, 16); drive(0, 0); drive(1, 16);
        wait_idle();
        verify_all("R4 burst");

        // busy timing
        drive(1, 48);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", "busy after first word", int'(busy), 1);
        b = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) b++;
            else break;
        end
        check("R7", "busy length", b, N + 2);
        verify_all("R7 settle");

        // loads that must be refused
        sel = m_node[5];
        drive(1, sel);
        @(negedge clk);
        in_valid = 1'b1; in_pattern = PW'(sel); model_apply(sel);
        load_en = 1'b1; load_addr = N'(5); load_pattern = PW'(~sel);
        @(negedge clk);
        in_valid = 1'b0; load_addr = N'(12); load_pattern = 8'h01;
        check("R6", "busy during refused load", int'(busy), 1);
        @(negedge clk);
        load_en = 1'b0;
        wait_idle();
        read_node(5, v, p, c);
        check("R6", "node 5 pattern kept", p, m_node[5]);
        check("R6", "node 5 count kept", c, m_cnt[5]);
        read_node(12, v, p, c);
        check("R6", "node 12 pattern kept", p, m_node[12]);

        // reload clears a count
        do_load(8, m_node[8]);
        read_node(8, v, p, c);
        check("R2", "reload clears count", c, 0);

        // random trees and random streams
        for (int r = 0; r < 4; r++) begin
            for (int a = 1; a <= NN; a++) do_load(a, int'($urandom % 256));
            for (int i = 0; i < 300; i++) begin
                if ($urandom % 4 == 0) drive(0, 0);
                else if ($urandom % 2 == 0) drive(1, m_node[1 + ($urandom % NN)]);
                else drive(1, int'($urandom % 256));
            end
            wait_idle();
            verify_all("random R3 R4 R5");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule